// File: doc/BRIEF.md
# Serial Character Transmitter with Modem Control

This block turns bytes from a host into a serial bit stream on a single transmit line. A byte enters a one-character holding buffer through a valid/ready handshake. From there it moves into a shift register and goes out least significant bit first, one bit for each pulse of an external bit-clock enable. In asynchronous mode every character is wrapped in a start bit, an optional even or odd parity bit and a stop bit, and the line rests at mark between characters. In the two synchronous modes the line is never left idle while sending is allowed: a stored sync character fills every gap. In bisync mode the fill is a fixed pair of characters, and the pair is never broken.

A small command register holds the transmit enable and the levels of the two active-low modem outputs, request-to-send and data-terminal-ready. A new character can start only when the enable bit is set and the active-low clear-to-send input is low. Once a data character is on the line, any byte already in the holding buffer follows it, even if permission is withdrawn in the meantime. Two flags follow the buffer: transmit-empty and transmit-ready. A status byte reports those two flags and the data-set-ready input.

Back-pressure on the write side works as follows. `wr_ready` is high exactly when the holding buffer is empty. A byte is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low the host must hold the byte, and `wr_data` is ignored.

Top module: `usart_tx`

## Requirements
- R1: While `rst_n` is low, `txd`=1, `wr_ready`=1, `txempty`=1, `txrdy`=0, `rts_n`=1 and `dtr_n`=1, and the command register is cleared.
- R2: A command write (`cmd_wr`=1) stores `cmd_wdata`. From the next cycle, bit 5 drives `rts_n` and bit 1 drives `dtr_n`, each inverted (1 gives a low pin). Bit 0 is the transmit enable.
- R3: `status` bit 7 is the inverse of `dsr_n`, bit 2 is `txempty`, bit 0 is `txrdy`, and every other bit is 0. The byte follows its inputs in the same cycle.
- R4: `wr_ready` is high exactly when the holding buffer is empty. After an accepted write, `wr_ready` and `txempty` are low from the next cycle on.
- R5: `txrdy` is high exactly when the holding buffer is empty, command bit 0 is 1 and `cts_n` is low.
- R6: The line changes only on a clock edge where `bit_en` is high, one bit per pulse. An asynchronous character is sent in this order: 0, data bits 0 to 7, then the parity bit if `cfg_par_en`=1, then 1. With `cfg_par_odd`=0 the parity bit makes the number of ones in data plus parity even. With `cfg_par_odd`=1 it makes that number odd.
- R7: When no character is being sent, a new one is started only if the enable bit is 1 and `cts_n` is 0. Otherwise the line stays at 1, and a buffered byte waits.
- R8: `cfg_mode`=1 selects sync mode and `cfg_mode`=2 selects bisync mode. Any other value selects asynchronous mode. In the two sync modes, a character is sent as 8 bits with no start, stop or parity bit. When sending is allowed and no byte is buffered, `cfg_sync1` is sent as fill.
- R9: In bisync mode, every fill of `cfg_sync1` is followed directly by `cfg_sync2`. This holds even if permission drops or a byte arrives in between.
- R10: When a data character ends and the buffer holds a byte, that byte is sent next, whether or not sending is still allowed.
- R11: `txempty` is low while the buffer is full or a data character is still being sent. It rises on the `bit_en` edge that ends the last data character when no byte follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| cfg_mode | input | 2 | 1 sync, 2 bisync, other async |
| cfg_par_en | input | 1 | Add parity bit in async mode |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_sync1 | input | 8 | First sync character |
| cfg_sync2 | input | 8 | Second sync character (bisync) |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command value |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Holding buffer empty, byte accepted |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| txempty | output | 1 | No data held in the block |
| txrdy | output | 1 | Buffer empty and sending allowed |
| status | output | 8 | Status byte |

## Verification
Results arrive at three different times.

- **Serial line:** a bit sampled on a rising edge with `bit_en` high appears on `txd` one cycle later. Any start, parity, stop or sync decision is taken on that same edge.
- **Handshake and command:** `wr_ready`, `txempty`, `rts_n` and `dtr_n` react one cycle after the accepting or writing edge.
- **Combinational flags:** `txrdy` and `status` follow `cts_n` and `dsr_n` within the same cycle.

A behavioural model is advanced on every rising edge from the same inputs. All outputs are compared with it on the following falling edge, so each result is checked in the first cycle it is due. Because the comparison runs every cycle, a result that comes early or late is also caught.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_BISYNC = 2'd2,
    MODE_ALT    = 2'd3
  } tx_mode_e;

  typedef enum logic [1:0] {
    SRC_MARK  = 2'd0,
    SRC_DATA  = 2'd1,
    SRC_SYNC1 = 2'd2,
    SRC_SYNC2 = 2'd3
  } tx_src_e;

endpackage

// File: rtl/usart_tx_cmd.sv
module usart_tx_cmd #(
  parameter int CMD_W   = 8,
  parameter int EN_BIT  = 0,
  parameter int DTR_BIT = 1,
  parameter int RTS_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic             tx_en,
  output logic             rts_n,
  output logic             dtr_n
);

  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cmd_wdata;
  end

  assign tx_en = cmd_q[EN_BIT];
  assign rts_n = ~cmd_q[RTS_BIT];
  assign dtr_n = ~cmd_q[DTR_BIT];

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^cmd_q;

  // R2
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (rts_n == !$past(cmd_wdata[RTS_BIT])));

  // R2
  dtr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (dtr_n == !$past(cmd_wdata[DTR_BIT])));

endmodule

// File: rtl/usart_tx_hold.sv
module usart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign wr_ready = ~full_q;
  assign full     = full_q;
  assign data     = data_q;

  // R4
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/usart_tx_shift.sv
module usart_tx_shift
  import usart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] sync1,
  input  logic [DATA_W-1:0] sync2,
  input  logic              go,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              txd,
  output logic              data_active
);

  localparam int FR_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(FR_W + 1);

  logic [FR_W-1:0]   sh_q, frm;
  logic [CNT_W-1:0]  rem_q, len;
  logic              txd_q, cur_data_q, pend2_q;
  logic              is_sync, at_end, par_bit;
  logic [DATA_W-1:0] chr;
  tx_src_e           src;

  always_comb begin
    is_sync = (mode == MODE_SYNC) || (mode == MODE_BISYNC);
    at_end  = (rem_q == '0);
    if (pend2_q)                         src = SRC_SYNC2;
    else if (hold_full && (go || cur_data_q)) src = SRC_DATA;
    else if (is_sync && go)              src = SRC_SYNC1;
    else                                 src = SRC_MARK;
  end

  always_comb begin
    case (src)
      SRC_SYNC1: chr = sync1;
      SRC_SYNC2: chr = sync2;
      default:   chr = hold_data;
    endcase
    par_bit = (^chr) ^ par_odd;
    frm     = '1;
    len     = CNT_W'(DATA_W);
    if (src == SRC_DATA && !is_sync) begin
      frm[0]        = 1'b0;
      frm[DATA_W:1] = chr;
      if (par_en) frm[DATA_W+1] = par_bit;
      len = CNT_W'(DATA_W + 2) + CNT_W'(par_en);
    end else begin
      frm[DATA_W-1:0] = chr;
    end
  end

  assign take = bit_en && at_end && (src == SRC_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '1;
      rem_q      <= '0;
      txd_q      <= 1'b1;
      cur_data_q <= 1'b0;
      pend2_q    <= 1'b0;
    end else if (bit_en) begin
      if (!at_end) begin
        txd_q <= sh_q[0];
        sh_q  <= sh_q >> 1;
        rem_q <= rem_q - 1'b1;
      end else if (src == SRC_MARK) begin
        txd_q      <= 1'b1;
        cur_data_q <= 1'b0;
      end else begin
        txd_q      <= frm[0];
        sh_q       <= frm >> 1;
        rem_q      <= len - 1'b1;
        cur_data_q <= (src == SRC_DATA);
        pend2_q    <= (src == SRC_SYNC1) && (mode == MODE_BISYNC);
      end
    end
  end

  assign txd         = txd_q;
  assign data_active = cur_data_q;

  // R6
  line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= CNT_W'(FR_W - 1));

  // R9
  pair_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend2_q && bit_en && at_end) |=> (!pend2_q && !cur_data_q));

endmodule

// File: rtl/usart_tx.sv
module usart_tx #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [DATA_W-1:0] cfg_sync1,
  input  logic [DATA_W-1:0] cfg_sync2,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              cts_n,
  input  logic              dsr_n,
  output logic              txd,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              txempty,
  output logic              txrdy,
  output logic [7:0]        status
);

  logic              tx_en, go, take, hold_full, data_active;
  logic [DATA_W-1:0] hold_data;

  usart_tx_cmd #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .tx_en(tx_en), .rts_n(rts_n), .dtr_n(dtr_n)
  );

  usart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .take(take), .full(hold_full), .data(hold_data)
  );

  assign go = tx_en & ~cts_n;

  usart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(cfg_mode),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .sync1(cfg_sync1),
    .sync2(cfg_sync2), .go(go), .hold_full(hold_full), .hold_data(hold_data),
    .take(take), .txd(txd), .data_active(data_active)
  );

  assign txempty = ~hold_full & ~data_active;
  assign txrdy   = ~hold_full & go;
  assign status  = {~dsr_n, 4'b0000, txempty, 1'b0, txrdy};

  // R4
  acc_txempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!txempty && !wr_ready));

  // R4
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);

  // R11
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txempty) |-> $past(bit_en));

endmodule

// File: tb/sim_usart_tx.sv
`timescale 1ns/1ps
module sim_usart_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [7:0] cfg_sync1 = 8'h16, cfg_sync2 = 8'h7E;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cts_n = 1'b0, dsr_n = 1'b1;
  logic       wr_ready, txd, rts_n, dtr_n, txempty, txrdy;
  logic [7:0] status;

  always #5 clk = ~clk;

  usart_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_mode(cfg_mode),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_sync1(cfg_sync1), .cfg_sync2(cfg_sync2),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .cts_n(cts_n), .dsr_n(dsr_n), .txd(txd), .rts_n(rts_n), .dtr_n(dtr_n),
    .txempty(txempty), .txrdy(txrdy), .status(status)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int   m_buf[$];
  int   m_bits[$];
  bit   m_txd = 1'b1, m_cur = 1'b0, m_pend2 = 1'b0;
  logic [7:0] m_cmd = 8'h00;

  function automatic void load_char(input logic [7:0] c, input bit framed);
    m_bits.delete();
    if (framed) m_bits.push_back(0);
    for (int i = 0; i < 8; i++) m_bits.push_back(int'(c[i]));
    if (framed) begin
      if (cfg_par_en) m_bits.push_back(int'((^c) ^ cfg_par_odd));
      m_bits.push_back(1);
    end
    m_txd = m_bits.pop_front() != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_buf.delete(); m_bits.delete();
      m_txd = 1'b1; m_cur = 1'b0; m_pend2 = 1'b0; m_cmd = 8'h00;
    end else begin
      bit go, acc, syncm;
      go    = m_cmd[0] && !cts_n;
      acc   = wr_valid && (m_buf.size() == 0);
      syncm = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
      if (bit_en) begin
        if (m_bits.size() > 0) m_txd = m_bits.pop_front() != 0;
        else if (m_pend2) begin
          load_char(cfg_sync2, 1'b0); m_pend2 = 1'b0; m_cur = 1'b0;
        end else if (m_buf.size() > 0 && (go || m_cur)) begin
          load_char(8'(m_buf.pop_front()), !syncm); m_cur = 1'b1;
        end else if (syncm && go) begin
          load_char(cfg_sync1, 1'b0); m_cur = 1'b0; m_pend2 = (cfg_mode == 2'd2);
        end else begin
          m_txd = 1'b1; m_cur = 1'b0;
        end
      end
      if (acc) m_buf.push_back(int'(wr_data));
      if (cmd_wr) m_cmd = cmd_wdata;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        chk("R1 txd", {7'd0, txd}, 8'd1);
        chk("R1 wr_ready", {7'd0, wr_ready}, 8'd1);
        chk("R1 txempty", {7'd0, txempty}, 8'd1);
        chk("R1 txrdy", {7'd0, txrdy}, 8'd0);
        chk("R1 rts_n", {7'd0, rts_n}, 8'd1);
        chk("R1 dtr_n", {7'd0, dtr_n}, 8'd1);
      end else begin
        bit e_empty, e_rdy;
        e_empty = (m_buf.size() == 0) && !m_cur;
        e_rdy   = (m_buf.size() == 0) && m_cmd[0] && !cts_n;
        chk("R6 R7 R8 R9 R10 txd", {7'd0, txd}, {7'd0, m_txd});
        chk("R4 wr_ready", {7'd0, wr_ready}, {7'd0, m_buf.size() == 0});
        chk("R4 R11 txempty", {7'd0, txempty}, {7'd0, e_empty});
        chk("R5 txrdy", {7'd0, txrdy}, {7'd0, e_rdy});
        chk("R2 rts_n", {7'd0, rts_n}, {7'd0, !m_cmd[5]});
        chk("R2 dtr_n", {7'd0, dtr_n}, {7'd0, !m_cmd[1]});
        chk("R3 status", status, {!dsr_n, 4'b0000, e_empty, 1'b0, e_rdy});
      end
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      bit_en = (cnt == 3);
      cnt = (cnt + 1) % 4;
    end
  end

  task automatic idle(input int bits);
    repeat (bits * 4) @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [7:0] v);
    @(posedge clk); #1;
    cmd_wr = 1'b1; cmd_wdata = v;
    @(posedge clk); #1;
    cmd_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    @(posedge clk); #1;
    while (!wr_ready) begin @(posedge clk); #1; end
    wr_valid = 1'b1; wr_data = b;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    // R7: byte waits while disabled
    put(8'h81); idle(6);
    // R2: enable, DTR, RTS
    cmd(8'h23); idle(14);
    // R6: async without parity, back to back
    put(8'hA5); put(8'h3C); idle(26);
    // R3: DSR
    dsr_n = 1'b0; idle(2); dsr_n = 1'b1; idle(1);
    // R6: even then odd parity
    cfg_par_en = 1'b1; put(8'h96); idle(13);
    cfg_par_odd = 1'b1; put(8'h01); idle(13);
    // R5 R7: CTS blocks start
    cts_n = 1'b1; put(8'h55); idle(10); cts_n = 1'b0; idle(14);
    // R10: disable while sending, buffered byte drains
    cfg_par_en = 1'b0;
    put(8'hF0); put(8'h0F); idle(3); cmd(8'h20); idle(26);
    cmd(8'h23); idle(2);
    // R8: sync fill and data
    cfg_mode = 2'd1; idle(20); put(8'hC3); idle(20);
    cmd(8'h22); idle(12);
    // R9: bisync, disable during first sync
    cfg_mode = 2'd2; cmd(8'h23); idle(3); cmd(8'h22); idle(20);
    // R9: byte arriving during the first sync of a pair
    cmd(8'h23); idle(3); put(8'h5A); idle(30);
    cts_n = 1'b1; idle(20); cts_n = 1'b0; idle(10);
    // R8: mode 3 behaves as async
    cfg_mode = 2'd3; cmd(8'h02); idle(12); put(8'hE7); idle(6);
    cmd(8'h01); idle(16);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule